// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

A single copy channel that moves data between two descriptor rings kept in a shared word memory. Software fills source descriptors with a buffer address, a byte count and a flags word. It also places empty receive buffers on the destination ring. It then moves each ring's write index forward through a small register port. The engine watches both rings. Whenever a source descriptor and a destination buffer are both pending, it copies the source data into the next destination buffer. It writes the final byte count and flags back into the destination descriptor, and only after that does it move its own read indices forward.

Several source descriptors may be chained with a gather flag so that their data lands back to back in one destination buffer and produces one completion. A destination descriptor whose byte count is still zero has not been completed. Optional byte reversal inside each 32-bit word can be requested per descriptor or per ring. A source descriptor longer than a configured limit is dropped and flagged in a status bit.

Memory is reached through a plain request port with one cycle of read latency. Each descriptor is two words: word 0 holds the buffer address, and word 1 holds the flags in bits 31:16 and the byte count in bits 15:0. Descriptor `i` of a ring sits at `base + 8*i`.

Top module: `copy_engine`

## Requirements
- R1: For an accepted source descriptor of n bytes, the engine copies ceil(n/4) words from the source buffer to consecutive words of the destination buffer. The destination word that follows the copied data is left unchanged.
- R2: On completion, destination descriptor word 1 holds the total byte count in bits 15:0 and, in bits 31:16, the flags of the last accepted source descriptor with the gather bit (flag bit 0) cleared. The transfer ID (flag bits 15:4) and the swap bit (flag bit 1) are therefore preserved.
- R3: Ring sizes are powers of two. Every index wraps by ANDing with (entries-1), and a value written to a write-index register is stored ANDed with (entries-1).
- R4: The free-count registers read (read_index - 1 - write_index) & (entries-1). The engine never advances a read index that equals the write index.
- R5: A source descriptor with the gather bit set is followed by the next descriptors, up to and including the first one without the bit. The whole chain goes into one destination buffer with one completion. No completion occurs while the chain is unfinished.
- R6: The engine writes the nonzero byte count into the destination descriptor before the destination read index advances, and the index advances by exactly one per completed chain.
- R7: When the descriptor swap bit (flag bit 1) is set, the bytes of every copied word are reversed.
- R8: Control bit 16 reverses the bytes of words read from source buffers, and control bit 17 reverses the bytes of words written to destination buffers. The final byte order is the XOR of these two bits and the descriptor swap bit.
- R9: The engine leaves idle only when the source read index differs from the source write index and the destination read index differs from the destination write index. Otherwise it makes no memory access and no index moves.
- R10: A source byte count larger than control bits 15:0 sets status bit 0. The descriptor is skipped: the source read index advances, and no data or completion is written. Writing 1 to status bit 0 clears it. A chain with no accepted bytes does not consume the destination buffer.
- R11: After reset, the bases and all indices read 0, both sizes read 2^IDX_W, the control register reads 0x0000FFFF, the status reads 0 and both free counts read 2^IDX_W-1.
- R12: Register word addresses: 0 source base, 1 source size, 2 source write index, 3 source read index, 4 destination base, 5 destination size, 6 destination write index, 7 destination read index, 8 control, 9 status, 10 source free count, 11 destination free count. Read indices and free counts are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when set, read otherwise |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
A wrong read index or a wrong wrap mask shows up within one completion. The readback index disagrees with the expected count, or the next descriptor lands in the wrong buffer slot. A wrong gather or skip decision shows within one chain: the destination index moves too early or not at all, or the written-back byte count is off. A swap error is visible in the very first copied word. Sweeps of payload length, ring wrap and swap combinations therefore expose most faults after a few dozen cycles.

// File: rtl/ce_pkg.sv
package ce_pkg;

    localparam logic [3:0] RA_SRC_BASE = 4'd0;
    localparam logic [3:0] RA_SRC_SIZE = 4'd1;
    localparam logic [3:0] RA_SRC_WR   = 4'd2;
    localparam logic [3:0] RA_SRC_RD   = 4'd3;
    localparam logic [3:0] RA_DST_BASE = 4'd4;
    localparam logic [3:0] RA_DST_SIZE = 4'd5;
    localparam logic [3:0] RA_DST_WR   = 4'd6;
    localparam logic [3:0] RA_DST_RD   = 4'd7;
    localparam logic [3:0] RA_CTRL     = 4'd8;
    localparam logic [3:0] RA_STATUS   = 4'd9;
    localparam logic [3:0] RA_SRC_FREE = 4'd10;
    localparam logic [3:0] RA_DST_FREE = 4'd11;

    localparam int FLG_GATHER = 0;
    localparam int FLG_SWAP   = 1;
    localparam int NUM_RINGS  = 2;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DST_ADDR, ST_SRC_REQ, ST_SRC_ADDR, ST_SRC_META,
        ST_RD, ST_WR, ST_WB, ST_ADV
    } eng_state_e;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] nbytes;
    } desc_meta_t;

    typedef struct packed {
        logic        dst_swap;
        logic        src_swap;
        logic [15:0] max_len;
    } ctrl_t;

    function automatic logic [31:0] rev_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/ce_ring.sv
module ce_ring #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             base_we,
    input  logic             size_we,
    input  logic             wr_we,
    input  logic [31:0]      wdata,
    input  logic             adv,
    output logic [31:0]      base,
    output logic [IDX_W:0]   size,
    output logic [IDX_W-1:0] mask,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] free_cnt
);
    localparam logic [IDX_W:0] SIZE_RST = (IDX_W+1)'(1) << IDX_W;

    assign mask     = IDX_W'(size - (IDX_W+1)'(1));
    assign free_cnt = (rd_idx - IDX_W'(1) - wr_idx) & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            base   <= '0;
            size   <= SIZE_RST;
            wr_idx <= '0;
            rd_idx <= '0;
        end else begin
            if (base_we) base <= wdata;
            if (size_we) size <= wdata[IDX_W:0];
            if (wr_we)   wr_idx <= wdata[IDX_W-1:0] & mask;
            if (adv)     rd_idx <= (rd_idx + IDX_W'(1)) & mask;
        end
    end
endmodule

// File: rtl/ce_csr.sv
module ce_csr
    import ce_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                reg_we,
    input  logic [3:0]                          reg_addr,
    input  logic [31:0]                         reg_wdata,
    output logic [31:0]                         reg_rdata,
    input  logic [NUM_RINGS-1:0][31:0]          r_base,
    input  logic [NUM_RINGS-1:0][IDX_W:0]       r_size,
    input  logic [NUM_RINGS-1:0][IDX_W-1:0]     r_wr,
    input  logic [NUM_RINGS-1:0][IDX_W-1:0]     r_rd,
    input  logic [NUM_RINGS-1:0][IDX_W-1:0]     r_free,
    output logic [NUM_RINGS-1:0]                base_we,
    output logic [NUM_RINGS-1:0]                size_we,
    output logic [NUM_RINGS-1:0]                wr_we,
    input  logic                                err_set,
    output ctrl_t                               ctrl,
    output logic                                err_q
);
    // Ring g owns word addresses {0, g, sub[1:0]}
    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_dec
        localparam logic [3:0] RB = 4'(g * 4);
        assign base_we[g] = reg_we && (reg_addr == RB);
        assign size_we[g] = reg_we && (reg_addr == RB + 4'd1);
        assign wr_we[g]   = reg_we && (reg_addr == RB + 4'd2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '{dst_swap: 1'b0, src_swap: 1'b0, max_len: 16'hFFFF};
            err_q <= 1'b0;
        end else begin
            if (reg_we && reg_addr == RA_CTRL) ctrl <= reg_wdata[17:0];
            if (err_set)
                err_q <= 1'b1;
            else if (reg_we && reg_addr == RA_STATUS && reg_wdata[0])
                err_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr[3]) begin
            case (reg_addr[1:0])
                2'd0: reg_rdata = r_base[reg_addr[2]];
                2'd1: reg_rdata = 32'(r_size[reg_addr[2]]);
                2'd2: reg_rdata = 32'(r_wr[reg_addr[2]]);
                default: reg_rdata = 32'(r_rd[reg_addr[2]]);
            endcase
        end else begin
            case (reg_addr)
                RA_CTRL:     reg_rdata = 32'(ctrl);
                RA_STATUS:   reg_rdata = {31'd0, err_q};
                RA_SRC_FREE: reg_rdata = 32'(r_free[0]);
                RA_DST_FREE: reg_rdata = 32'(r_free[1]);
                default:     reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ce_engine.sv
module ce_engine
    import ce_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [31:0]      src_base,
    input  logic [31:0]      dst_base,
    input  logic [IDX_W-1:0] src_rd,
    input  logic [IDX_W-1:0] src_wr,
    input  logic [IDX_W-1:0] dst_rd,
    input  logic [IDX_W-1:0] dst_wr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic             src_adv,
    output logic             dst_adv,
    output logic             err_set,
    output logic             busy
);
    localparam int CNT_W = 14;

    eng_state_e       state;
    logic [31:0]      sbuf, dbuf;
    logic [15:0]      total;
    logic [15:0]      wofs;
    logic [CNT_W-1:0] k, words;
    logic [15:0]      cur_flags, last_flags;

    desc_meta_t       meta;
    logic             src_avail, work, skip, last_word, rev;
    logic [31:0]      src_desc, dst_desc, copy_word;

    assign meta      = mem_rdata;
    assign src_avail = (src_rd != src_wr);
    assign work      = src_avail && (dst_rd != dst_wr);
    assign skip      = (meta.nbytes > ctrl.max_len) || (meta.nbytes == 16'd0);
    assign last_word = (k == words - CNT_W'(1));
    assign src_desc  = src_base + (32'(src_rd) << 3);
    assign dst_desc  = dst_base + (32'(dst_rd) << 3);
    assign rev       = ctrl.src_swap ^ cur_flags[FLG_SWAP] ^ ctrl.dst_swap;
    assign copy_word = rev ? rev_bytes(mem_rdata) : mem_rdata;
    assign busy      = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            sbuf       <= '0;
            dbuf       <= '0;
            total      <= '0;
            wofs       <= '0;
            k          <= '0;
            words      <= '0;
            cur_flags  <= '0;
            last_flags <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    total <= '0;
                    wofs  <= '0;
                    if (work) state <= ST_DST_ADDR;
                end
                ST_DST_ADDR: begin
                    dbuf  <= mem_rdata;
                    state <= ST_SRC_REQ;
                end
                ST_SRC_REQ:  if (src_avail) state <= ST_SRC_ADDR;
                ST_SRC_ADDR: begin
                    sbuf  <= mem_rdata;
                    state <= ST_SRC_META;
                end
                ST_SRC_META: begin
                    cur_flags <= meta.flags;
                    k         <= '0;
                    words     <= CNT_W'((17'(meta.nbytes) + 17'd3) >> 2);
                    if (skip) begin
                        if (meta.flags[FLG_GATHER]) state <= ST_SRC_REQ;
                        else if (total != 16'd0)    state <= ST_WB;
                        else                        state <= ST_IDLE;
                    end else begin
                        total      <= total + meta.nbytes;
                        last_flags <= meta.flags;
                        state      <= ST_RD;
                    end
                end
                ST_RD: state <= ST_WR;
                ST_WR: begin
                    k    <= k + CNT_W'(1);
                    wofs <= wofs + 16'd1;
                    if (!last_word)                  state <= ST_RD;
                    else if (cur_flags[FLG_GATHER])  state <= ST_SRC_REQ;
                    else                             state <= ST_WB;
                end
                ST_WB:   state <= ST_ADV;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        src_adv   = 1'b0;
        dst_adv   = 1'b0;
        err_set   = 1'b0;
        case (state)
            ST_IDLE: if (work) begin
                mem_req  = 1'b1;
                mem_addr = dst_desc;
            end
            ST_SRC_REQ: if (src_avail) begin
                mem_req  = 1'b1;
                mem_addr = src_desc;
            end
            ST_SRC_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = src_desc + 32'd4;
            end
            ST_SRC_META: begin
                src_adv = skip;
                err_set = meta.nbytes > ctrl.max_len;
            end
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = sbuf + (32'(k) << 2);
            end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dbuf + (32'(wofs) << 2);
                mem_wdata = copy_word;
                src_adv   = last_word;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_desc + 32'd4;
                mem_wdata = {last_flags & ~(16'd1 << FLG_GATHER), total};
            end
            ST_ADV:  dst_adv = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/copy_engine.sv
module copy_engine
    import ce_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata
);
    logic [NUM_RINGS-1:0][31:0]      r_base;
    logic [NUM_RINGS-1:0][IDX_W:0]   r_size;
    logic [NUM_RINGS-1:0][IDX_W-1:0] r_mask, r_wr, r_rd, r_free;
    logic [NUM_RINGS-1:0]            base_we, size_we, wr_we, adv;
    ctrl_t                           ctrl;
    logic                            err_set, err_q, busy;
    logic                            src_adv, dst_adv;

    // Named views for the bound checker
    logic [IDX_W-1:0] src_rd_v, src_wr_v, dst_rd_v, dst_wr_v, src_mask_v;
    logic [31:0]      dst_base_v;
    assign src_rd_v   = r_rd[0];
    assign src_wr_v   = r_wr[0];
    assign dst_rd_v   = r_rd[1];
    assign dst_wr_v   = r_wr[1];
    assign src_mask_v = r_mask[0];
    assign dst_base_v = r_base[1];

    assign adv = {dst_adv, src_adv};

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        ce_ring #(.IDX_W(IDX_W)) u_ring (
            .clk      (clk),
            .rst      (rst),
            .base_we  (base_we[g]),
            .size_we  (size_we[g]),
            .wr_we    (wr_we[g]),
            .wdata    (reg_wdata),
            .adv      (adv[g]),
            .base     (r_base[g]),
            .size     (r_size[g]),
            .mask     (r_mask[g]),
            .wr_idx   (r_wr[g]),
            .rd_idx   (r_rd[g]),
            .free_cnt (r_free[g])
        );
    end

    ce_csr #(.IDX_W(IDX_W)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .r_base    (r_base),
        .r_size    (r_size),
        .r_wr      (r_wr),
        .r_rd      (r_rd),
        .r_free    (r_free),
        .base_we   (base_we),
        .size_we   (size_we),
        .wr_we     (wr_we),
        .err_set   (err_set),
        .ctrl      (ctrl),
        .err_q     (err_q)
    );

    ce_engine #(.IDX_W(IDX_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .src_base  (r_base[0]),
        .dst_base  (r_base[1]),
        .src_rd    (r_rd[0]),
        .src_wr    (r_wr[0]),
        .dst_rd    (r_rd[1]),
        .dst_wr    (r_wr[1]),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .src_adv   (src_adv),
        .dst_adv   (dst_adv),
        .err_set   (err_set),
        .busy      (busy)
    );
endmodule

// File: rtl/ce_checker.sv
module ce_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] src_rd,
    input logic [IDX_W-1:0] src_wr,
    input logic [IDX_W-1:0] dst_rd,
    input logic [IDX_W-1:0] dst_wr,
    input logic [IDX_W-1:0] src_mask,
    input logic [31:0]      dst_base,
    input logic             src_adv,
    input logic             dst_adv,
    input logic             busy,
    input logic             err_q,
    input logic             mem_req,
    input logic             mem_we,
    input logic [31:0]      mem_addr,
    input logic [31:0]      mem_wdata
);
    logic primed;
    always_ff @(posedge clk) primed <= !rst;

    // R3: the source read index only ever steps by one, wrapping on the mask
    assert_rd_step_R3: assert property (@(posedge clk) disable iff (rst || !primed)
        (src_rd != $past(src_rd)) |-> (src_rd == (($past(src_rd) + IDX_W'(1)) & $past(src_mask))));

    // R4: never consume a source slot that software has not posted
    assert_no_overrun_R4: assert property (@(posedge clk) disable iff (rst || !primed)
        src_adv |-> (src_rd != src_wr));

    // R6: the destination index moves only right after a nonzero count write-back
    assert_wb_before_adv_R6: assert property (@(posedge clk) disable iff (rst || !primed)
        dst_adv |-> $past(mem_req && mem_we && mem_wdata[15:0] != 16'd0
                          && mem_addr == dst_base + (32'(dst_rd) << 3) + 32'd4));

    // R9: the engine leaves idle only with work on both rings
    assert_start_needs_work_R9: assert property (@(posedge clk) disable iff (rst || !primed)
        $rose(busy) |-> $past(src_rd != src_wr && dst_rd != dst_wr));

    // R10: an oversize error is always paired with a skipped source slot
    assert_err_skips_R10: assert property (@(posedge clk) disable iff (rst || !primed)
        $rose(err_q) |-> (src_rd != $past(src_rd)));
endmodule

bind copy_engine ce_checker #(.IDX_W(IDX_W)) u_ce_checker (
    .clk       (clk),
    .rst       (rst),
    .src_rd    (src_rd_v),
    .src_wr    (src_wr_v),
    .dst_rd    (dst_rd_v),
    .dst_wr    (dst_wr_v),
    .src_mask  (src_mask_v),
    .dst_base  (dst_base_v),
    .src_adv   (src_adv),
    .dst_adv   (dst_adv),
    .busy      (busy),
    .err_q     (err_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/copy_engine_bench.sv
`timescale 1ns/1ps
module copy_engine_bench;
    import ce_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;

    always #2 clk = ~clk;

    copy_engine u_copy_engine (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    logic [31:0] mem [0:1023];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:2]];
        end
    end

    localparam logic [31:0] MARK = 32'hDEADBEEF;
    localparam int RM = 3;          // ring of 4 entries
    localparam int SRC_RING_W = 0;  // word index of source ring
    localparam int DST_RING_W = 32; // word index of destination ring

    int checks = 0, fails = 0;
    int s_wr = 0, d_wr = 0, d_rd_exp = 0, tag_ctr = 1;
    int ch_len [4];
    logic [15:0] ch_flg [4];
    int ch_slot [4];
    int ch_tag [4];
    logic [31:0] rv;
    logic done = 1'b0;

    function automatic logic [31:0] swp(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] pat(input int slot, input int tag, input int j);
        return {8'(tag), 8'(j), 8'(slot) ^ 8'h5A, 8'(j * 3 + 1)};
    endfunction

    function automatic logic [15:0] mkflg(input int id, input bit sw, input bit g);
        return {12'(id), 2'b00, sw, g};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic post_dst();
        int slot = d_wr;
        mem[DST_RING_W + slot * 2]     = 32'h800 + 32'(slot * 128);
        mem[DST_RING_W + slot * 2 + 1] = 32'd0;
        for (int j = 0; j < 32; j++) mem[512 + slot * 32 + j] = MARK;
        d_wr = (d_wr + 1) & RM;
        reg_wr(RA_DST_WR, 32'(d_wr));
    endtask

    task automatic post_src(input int i);
        int slot = s_wr;
        ch_slot[i] = slot;
        ch_tag[i]  = tag_ctr;
        tag_ctr++;
        mem[SRC_RING_W + slot * 2]     = 32'h100 + 32'(slot * 64);
        mem[SRC_RING_W + slot * 2 + 1] = {ch_flg[i], 16'(ch_len[i])};
        for (int j = 0; j < 16; j++) mem[64 + slot * 16 + j] = pat(slot, ch_tag[i], j);
        s_wr = (s_wr + 1) & RM;
    endtask

    task automatic wait_rd(input logic [3:0] a, input int exp, input string req);
        logic [31:0] v;
        bit ok = 0;
        for (int t = 0; t < 3000; t++) begin
            reg_rd(a, v);
            if (v == 32'(exp)) begin ok = 1; break; end
        end
        if (!ok) chk(req, v, 32'(exp));
    endtask

    task automatic check_chain(input int n, input bit ssw, input bit dsw, input string req);
        int base = 512 + d_rd_exp * 32;
        int ofs = 0;
        int total = 0;
        logic [31:0] e;
        for (int i = 0; i < n; i++) begin
            for (int j = 0; j < (ch_len[i] + 3) / 4; j++) begin
                e = pat(ch_slot[i], ch_tag[i], j);
                if (ssw ^ ch_flg[i][1] ^ dsw) e = swp(e);
                chk(req, mem[base + ofs], e);
                ofs++;
            end
            total += ch_len[i];
        end
        chk({req, " R1 tail"}, mem[base + ofs], MARK);
        chk({req, " R2 desc"}, mem[DST_RING_W + d_rd_exp * 2 + 1],
            {ch_flg[n-1] & 16'hFFFE, 16'(total)});
        reg_rd(RA_SRC_RD, rv);
        chk({req, " R3 src rd"}, rv, 32'(s_wr));
        d_rd_exp = (d_rd_exp + 1) & RM;
    endtask

    task automatic run_chain(input int n, input bit ssw, input bit dsw, input string req);
        reg_wr(RA_CTRL, {14'd0, dsw, ssw, 16'd64});
        if (d_wr == d_rd_exp) post_dst();
        for (int i = 0; i < n; i++) post_src(i);
        reg_wr(RA_SRC_WR, 32'(s_wr));
        wait_rd(RA_DST_RD, (d_rd_exp + 1) & RM, {req, " R6 completion"});
        check_chain(n, ssw, dsw, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R11 reset values, R12 map
        for (int a = 0; a < 12; a++) begin
            logic [31:0] exp;
            case (a)
                1, 5:   exp = 32'd16;
                8:      exp = 32'h0000FFFF;
                10, 11: exp = 32'd15;
                default: exp = 32'd0;
            endcase
            reg_rd(4'(a), rv);
            chk("R11 R12 reset", rv, exp);
        end

        reg_wr(RA_SRC_BASE, 32'h000);
        reg_wr(RA_DST_BASE, 32'h080);
        reg_wr(RA_SRC_SIZE, 32'd4);
        reg_wr(RA_DST_SIZE, 32'd4);
        reg_rd(RA_SRC_FREE, rv);
        chk("R4 free after resize", rv, 32'd3);

        // R1 R2 single transfer
        ch_len[0] = 12; ch_flg[0] = mkflg(5, 0, 0);
        run_chain(1, 0, 0, "R1 R2 single");

        // R7 R3 length sweep with per-descriptor swap, wraps rings
        for (int len = 1; len <= 20; len++) begin
            ch_len[0] = len;
            ch_flg[0] = mkflg((len * 37) & 12'hFFF, len[0], 0);
            run_chain(1, 0, 0, "R7 R3 sweep");
        end

        // R5 gather sweep
        for (int n = 2; n <= 3; n++) begin
            for (int v = 0; v < 3; v++) begin
                for (int i = 0; i < n; i++) begin
                    ch_len[i] = 4 * (i + 1) + v * 5;
                    ch_flg[i] = mkflg(16 + n * 3 + v + i, (v + i) % 2 == 1, i < n - 1);
                end
                run_chain(n, 0, 0, "R5 gather");
            end
        end

        // R8 control swap enables
        for (int c = 0; c < 8; c++) begin
            ch_len[0] = 16;
            ch_flg[0] = mkflg(40 + c, c[2], 0);
            run_chain(1, c[0], c[1], "R8 ctrl swap");
        end

        // R5 unfinished chain gives no completion
        reg_wr(RA_CTRL, 32'd64);
        post_dst();
        ch_len[0] = 8;  ch_flg[0] = mkflg(70, 0, 1);
        post_src(0);
        reg_wr(RA_SRC_WR, 32'(s_wr));
        repeat (40) @(negedge clk);
        reg_rd(RA_DST_RD, rv);
        chk("R5 pending chain dst rd", rv, 32'(d_rd_exp));
        chk("R5 pending chain desc", mem[DST_RING_W + d_rd_exp * 2 + 1], 32'd0);
        ch_len[1] = 12; ch_flg[1] = mkflg(71, 1, 0);
        post_src(1);
        reg_wr(RA_SRC_WR, 32'(s_wr));
        wait_rd(RA_DST_RD, (d_rd_exp + 1) & RM, "R5 chain completion");
        check_chain(2, 0, 0, "R5 split chain");

        // R10 oversize skip
        reg_wr(RA_CTRL, 32'd16);
        post_dst();
        ch_len[0] = 20; ch_flg[0] = mkflg(80, 0, 0);
        post_src(0);
        reg_wr(RA_SRC_WR, 32'(s_wr));
        repeat (40) @(negedge clk);
        reg_rd(RA_STATUS, rv);
        chk("R10 err set", rv, 32'd1);
        reg_rd(RA_SRC_RD, rv);
        chk("R10 src skipped", rv, 32'(s_wr));
        reg_rd(RA_DST_RD, rv);
        chk("R10 dst kept", rv, 32'(d_rd_exp));
        chk("R10 desc untouched", mem[DST_RING_W + d_rd_exp * 2 + 1], 32'd0);
        chk("R10 data untouched", mem[512 + d_rd_exp * 32], MARK);
        reg_wr(RA_STATUS, 32'd1);
        reg_rd(RA_STATUS, rv);
        chk("R10 err clear", rv, 32'd0);
        ch_len[0] = 8; ch_flg[0] = mkflg(81, 0, 0);
        run_chain(1, 0, 0, "R10 reuse dst");

        // R9 no destination buffer: engine idles
        reg_wr(RA_CTRL, 32'd64);
        ch_len[0] = 8; ch_flg[0] = mkflg(90, 0, 0);
        post_src(0);
        reg_wr(RA_SRC_WR, 32'(s_wr));
        repeat (40) @(negedge clk);
        reg_rd(RA_SRC_RD, rv);
        chk("R9 idle src rd", rv, 32'((s_wr - 1) & RM));
        post_dst();
        wait_rd(RA_DST_RD, (d_rd_exp + 1) & RM, "R9 resume");
        check_chain(1, 0, 0, "R9 resume");

        // R3 R4 index masking and free counts (no destination buffer pending)
        for (int v = 0; v < 8; v++) begin
            reg_wr(RA_SRC_WR, 32'(v));
            reg_rd(RA_SRC_WR, rv);
            chk("R3 wr mask", rv, 32'(v & RM));
            reg_rd(RA_SRC_FREE, rv);
            chk("R4 src free", rv, 32'((s_wr - 1 - (v & RM)) & RM));
            reg_rd(RA_SRC_RD, rv);
            chk("R9 R4 src rd held", rv, 32'(s_wr));
        end
        reg_wr(RA_SRC_WR, 32'(s_wr));
        for (int v = 0; v < 8; v++) begin
            reg_wr(RA_DST_WR, 32'(v));
            reg_rd(RA_DST_FREE, rv);
            chk("R4 dst free", rv, 32'((d_rd_exp - 1 - (v & RM)) & RM));
            reg_rd(RA_DST_RD, rv);
            chk("R9 dst rd held", rv, 32'(d_rd_exp));
        end
        reg_wr(RA_DST_WR, 32'(d_rd_exp));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule